// File: doc/BRIEF.md
# ZUC Keystream Generator Core

This core produces the 32-bit keystream words of the ZUC stream cipher. It keeps a sixteen-cell shift register over the prime field GF(2^31−1), a bit-reorganization stage that picks half-words out of that register, and a nonlinear function with two 32-bit state registers and byte substitution tables held as constants.

The host pulses a start command with a 64-bit operand that supplies the two top cells. The fourteen lower cells come from seven packed 64-bit words, unless a resume flag says the register already holds valid lower cells. The core then runs its initialization rounds with a busy flag raised and afterwards offers one keystream word at a time on a valid/ready handshake. Expanding a user key and IV into cell values is left to the caller.

Top module: `zuc_keystream_core`

## Requirements
- R1: After reset `busy_o` and `ks_valid_o` are both low.
- R2: A start accepted while idle, or while keystream is offered, raises `busy_o` from the next cycle for exactly 33 cycles (32 init rounds plus one discarded round). `ks_valid_o` rises in the cycle `busy_o` falls.
- R3: A start pulse while `busy_o` is high is ignored: the initialization neither restarts nor lengthens, and its operands do not change the resulting keystream.
- R4: Load word j (bits 64j+63..64j of `load_words_i`) fills cell 2j from its bits 62..32 and cell 2j+1 from its bits 30..0. Cell 14 takes bits 62..32 of `start_word_i` and cell 15 takes bits 30..0. Bits 63 and 31 of every word are discarded.
- R5: With `resume_i` high at start, cells 0 to 13 keep their contents and `load_words_i` has no effect. Only cells 14 and 15 are replaced.
- R6: The keystream follows ZUC exactly: modular feedback with rotations 8, 20, 21, 17 and 15 on cells 0, 4, 10, 13 and 15; the F output shifted right by one is added during init rounds; the word is F xor X3; and the two state registers are cleared at start. With all cells set to the standard constants for an all-zero key and IV, the first two words are 0x27BEDE74 and 0x018082DA. For an all-ones key and IV they are 0x0657CFA0 and 0x7096398B.
- R7: A word transfers on a cycle with `ks_valid_o` and `ks_ready_i` both high, and the next word appears one cycle later. While `ks_ready_i` is low, `ks_data_o` and `ks_valid_o` hold.
- R8: A start while `ks_valid_o` is high drops `ks_valid_o` in the next cycle and restarts the cipher from the new operands.
- R9: A modular sum that would be zero is stored as 0x7FFFFFFF, so a newly shifted-in cell is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; ignored while busy |
| resume_i | input | 1 | Keep cells 0 to 13 at start |
| start_word_i | input | 64 | Source for cells 14 and 15 |
| load_words_i | input | 448 | Seven packed words for cells 0 to 13 |
| ks_ready_i | input | 1 | Consumer accepts the offered word |
| busy_o | output | 1 | Initialization rounds running |
| ks_valid_o | output | 1 | A keystream word is offered |
| ks_data_o | output | 32 | Offered keystream word |

## Verification
The cipher path is tried with two standard known-answer cell loads, all-zero and all-ones. These separate errors in the S-boxes, the linear transforms and the modular feedback, because a single wrong bit spreads through all 33 rounds. The same load with the discarded bits 63 and 31 set shows that the 31-bit cut works. A spurious start is injected at each of the 33 busy cycles to show that no round offset can disturb initialization. The handshake is then tried with varied stall lengths against a free-running reference sequence, a restart is issued while a word is offered, and a resumed start after reset (with garbage load words) is compared against an explicit zero load.

// File: rtl/zuc_pkg.sv
package zuc_pkg;
  localparam int CELL_W  = 31;
  localparam int WORD_W  = 32;
  localparam int N_CELLS = 16;
  localparam int N_LOAD  = 7;
  localparam int INIT_ROUNDS = 32;

  // 4-bit mixing boxes for the first S-box, entry 0 in the top nibble
  localparam logic [63:0] MIX_A = 64'h9F0EFF2A040C7539;
  localparam logic [63:0] MIX_B = 64'h8D6570C4B1EAF392;
  localparam logic [63:0] MIX_C = 64'h26A60DAF33D509CD;

  // second S-box in four 64-byte quarters, entry 0 in the top byte
  localparam logic [511:0] SB1_Q0 = {
    64'h55c263713bc84786, 64'h9f3cda5b29aafd77, 64'h8cc5940ca61a1300, 64'he3a8167240f9f842,
    64'h4426689681d9453e, 64'h1076c6a78b3943e1, 64'h3ab5562ac06db305, 64'h2266bfdc0bfa6248};
  localparam logic [511:0] SB1_Q1 = {
    64'hdd20110636c9c1cf, 64'hf62752bb69f5d487, 64'h7f844cd29c57a4bc, 64'h4f9adffed68d7aeb,
    64'h2b53d85ca11417fb, 64'h23d57d3067730809, 64'heeb7703f61b2198e, 64'h4ee54b938f5ddba9};
  localparam logic [511:0] SB1_Q2 = {
    64'hadf1ae2ecb0dfcf4, 64'h2d466e1d97e8d1e9, 64'h4d37a5755e839eab, 64'h829db91ce0cd4989,
    64'h01b6bd5824a25f38, 64'h7899159050b895e4, 64'hd091c7ceed0fb46f, 64'ha0ccf0024a79c3de};
  localparam logic [511:0] SB1_Q3 = {
    64'ha3efea51e66b18ec, 64'h1b2c80f774e7ff21, 64'h5a6a541e41319235, 64'hc433070aba7e0e34,
    64'h88b1987cf33d606c, 64'h7bcad31f32650428, 64'h64be859b2f598ad7, 64'hb025acaf1203e2f2};

  function automatic logic [3:0] nib(input logic [63:0] tab, input logic [3:0] i);
    return 4'(tab >> (4 * (15 - int'(i))));
  endfunction

  function automatic logic [7:0] sbox0(input logic [7:0] x);
    logic [3:0] t1, t2, t3;
    logic [7:0] y;
    t1 = x[7:4] ^ nib(MIX_A, x[3:0]);
    t2 = x[3:0] ^ nib(MIX_B, t1);
    t3 = t1 ^ nib(MIX_C, t2);
    y  = {t3, t2};
    return {y[2:0], y[7:3]};
  endfunction

  function automatic logic [7:0] sbox1(input logic [7:0] x);
    logic [511:0] q;
    case (x[7:6])
      2'd0:    q = SB1_Q0;
      2'd1:    q = SB1_Q1;
      2'd2:    q = SB1_Q2;
      default: q = SB1_Q3;
    endcase
    return 8'(q >> (8 * (63 - int'(x[5:0]))));
  endfunction

  function automatic logic [WORD_W-1:0] subst(input logic [WORD_W-1:0] x);
    return {sbox0(x[31:24]), sbox1(x[23:16]), sbox0(x[15:8]), sbox1(x[7:0])};
  endfunction

  function automatic logic [WORD_W-1:0] lin1(input logic [WORD_W-1:0] x);
    return x ^ {x[29:0], x[31:30]} ^ {x[21:0], x[31:22]} ^ {x[13:0], x[31:14]} ^ {x[7:0], x[31:8]};
  endfunction

  function automatic logic [WORD_W-1:0] lin2(input logic [WORD_W-1:0] x);
    return x ^ {x[23:0], x[31:24]} ^ {x[17:0], x[31:18]} ^ {x[9:0], x[31:10]} ^ {x[1:0], x[31:2]};
  endfunction

  function automatic logic [CELL_W-1:0] rotl31(input logic [CELL_W-1:0] v, input int k);
    return (v << k) | (v >> (CELL_W - k));
  endfunction

  function automatic logic [CELL_W-1:0] add_mod(input logic [CELL_W-1:0] a, input logic [CELL_W-1:0] b);
    logic [CELL_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    s = {1'b0, s[CELL_W-1:0]} + {{CELL_W{1'b0}}, s[CELL_W]};
    return (s[CELL_W-1:0] == '0) ? '1 : s[CELL_W-1:0];
  endfunction
endpackage

// File: rtl/zuc_lfsr.sv
module zuc_lfsr
  import zuc_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic                      resume_i,
  input  logic [N_LOAD*64-1:0]      load_words_i,
  input  logic [63:0]               start_word_i,
  input  logic                      step_i,
  input  logic                      init_mode_i,
  input  logic [CELL_W-1:0]         u_i,
  output logic [N_CELLS*CELL_W-1:0] cells_o
);
  localparam int N_LOW = 2 * N_LOAD;

  logic [CELL_W-1:0] cell_w [N_CELLS];
  logic [CELL_W-1:0] fb;
  logic [N_LOW+1:0]  unused_half_msb;

  always_comb begin
    fb = add_mod(cell_w[0], rotl31(cell_w[0], 8));
    fb = add_mod(fb, rotl31(cell_w[4], 20));
    fb = add_mod(fb, rotl31(cell_w[10], 21));
    fb = add_mod(fb, rotl31(cell_w[13], 17));
    fb = add_mod(fb, rotl31(cell_w[15], 15));
    if (init_mode_i) fb = add_mod(fb, u_i);
  end

  for (genvar j = 0; j < N_LOAD; j++) begin : g_msb
    assign unused_half_msb[2*j]   = load_words_i[64*j+63];
    assign unused_half_msb[2*j+1] = load_words_i[64*j+31];
  end
  assign unused_half_msb[N_LOW]   = start_word_i[63];
  assign unused_half_msb[N_LOW+1] = start_word_i[31];

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    logic [CELL_W-1:0] q, load_val, shift_in;
    logic keep;

    if (i < N_LOW) begin : g_low
      localparam int OFS = 64 * (i / 2) + ((i % 2 == 0) ? 32 : 0);
      assign load_val = load_words_i[OFS +: CELL_W];
      assign keep     = resume_i;
    end else begin : g_top
      localparam int OFS = 32 * (N_CELLS - 1 - i);
      assign load_val = start_word_i[OFS +: CELL_W];
      assign keep     = 1'b0;
    end

    if (i < N_CELLS - 1) begin : g_mid
      assign shift_in = cell_w[i+1];
    end else begin : g_head
      assign shift_in = fb;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             q <= '0;
      else if (load_i) begin
        if (!keep)             q <= load_val;
      end else if (step_i)     q <= shift_in;
    end

    assign cell_w[i] = q;
    assign cells_o[i*CELL_W +: CELL_W] = q;
  end

  // R9: folded modular sum never stores zero
  p_head_nonzero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> cell_w[N_CELLS-1] != '0);

  // R5: resumed start leaves the lower cells alone
  p_resume_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && resume_i |=> cell_w[0] == $past(cell_w[0]) && cell_w[N_LOW-1] == $past(cell_w[N_LOW-1]));
endmodule

// File: rtl/zuc_bitreorg.sv
module zuc_bitreorg
  import zuc_pkg::*;
(
  input  logic [N_CELLS*CELL_W-1:0] cells_i,
  output logic [WORD_W-1:0]         x0_o,
  output logic [WORD_W-1:0]         x1_o,
  output logic [WORD_W-1:0]         x2_o,
  output logic [WORD_W-1:0]         x3_o
);
  logic [CELL_W-1:0] s [N_CELLS];

  for (genvar i = 0; i < N_CELLS; i++) begin : g_unpack
    assign s[i] = cells_i[i*CELL_W +: CELL_W];
  end

  assign x0_o = {s[15][30:15], s[14][15:0]};
  assign x1_o = {s[11][15:0], s[9][30:15]};
  assign x2_o = {s[7][15:0],  s[5][30:15]};
  assign x3_o = {s[2][15:0],  s[0][30:15]};
endmodule

// File: rtl/zuc_nlf.sv
module zuc_nlf
  import zuc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              update_i,
  input  logic [WORD_W-1:0] x0_i,
  input  logic [WORD_W-1:0] x1_i,
  input  logic [WORD_W-1:0] x2_i,
  output logic [WORD_W-1:0] w_o
);
  logic [WORD_W-1:0] r1_q, r2_q, w1, w2, r1_d, r2_d;

  assign w_o  = (x0_i ^ r1_q) + r2_q;
  assign w1   = r1_q + x1_i;
  assign w2   = r2_q ^ x2_i;
  assign r1_d = subst(lin1({w1[15:0], w2[31:16]}));
  assign r2_d = subst(lin2({w2[15:0], w1[31:16]}));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r1_q <= '0;
      r2_q <= '0;
    end else if (clear_i) begin
      r1_q <= '0;
      r2_q <= '0;
    end else if (update_i) begin
      r1_q <= r1_d;
      r2_q <= r2_d;
    end
  end
endmodule

// File: rtl/zuc_keystream_core.sv
module zuc_keystream_core
  import zuc_pkg::*;
#(
  parameter int ROUNDS = INIT_ROUNDS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 resume_i,
  input  logic [63:0]          start_word_i,
  input  logic [N_LOAD*64-1:0] load_words_i,
  input  logic                 ks_ready_i,
  output logic                 busy_o,
  output logic                 ks_valid_o,
  output logic [WORD_W-1:0]    ks_data_o
);
  localparam int CNT_W = $clog2(ROUNDS + 1);

  logic busy_q, live_q;
  logic [CNT_W-1:0] cnt_q;
  logic start_take, last_round, consume, advance, init_mode;
  logic [N_CELLS*CELL_W-1:0] cells;
  logic [WORD_W-1:0] x0, x1, x2, x3, w;

  assign start_take = start_i && !busy_q;
  assign last_round = busy_q && (cnt_q == CNT_W'(ROUNDS));
  assign consume    = live_q && ks_ready_i;
  assign advance    = busy_q || consume;
  assign init_mode  = busy_q && !last_round;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      live_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_take) begin
      busy_q <= 1'b1;
      live_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (last_round) begin
        busy_q <= 1'b0;
        live_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  zuc_lfsr u_lfsr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (start_take),
    .resume_i     (resume_i),
    .load_words_i (load_words_i),
    .start_word_i (start_word_i),
    .step_i       (advance),
    .init_mode_i  (init_mode),
    .u_i          (w[WORD_W-1:1]),
    .cells_o      (cells)
  );

  zuc_bitreorg u_reorg (
    .cells_i (cells),
    .x0_o    (x0),
    .x1_o    (x1),
    .x2_o    (x2),
    .x3_o    (x3)
  );

  zuc_nlf u_nlf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (start_take),
    .update_i (advance),
    .x0_i     (x0),
    .x1_i     (x1),
    .x2_i     (x2),
    .w_o      (w)
  );

  assign busy_o     = busy_q;
  assign ks_valid_o = live_q;
  assign ks_data_o  = w ^ x3;

  p_busy_no_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ks_valid_o);

  p_init_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_round |=> !busy_o && ks_valid_o);

  p_start_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !last_round |=> busy_o && cnt_q == $past(cnt_q) + 1'b1);

  p_stall_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ks_valid_o && !ks_ready_i && !start_i |=> ks_valid_o && $stable(ks_data_o));

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ks_valid_o && start_i |=> busy_o && !ks_valid_o);
endmodule

// File: tb/zuc_keystream_core_tb.sv
module zuc_keystream_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, resume = 1'b0, ready = 1'b0;
  logic [63:0]  op = '0;
  logic [447:0] words = '0;
  logic busy, valid;
  logic [31:0] data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zuc_keystream_core dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .resume_i (resume),
    .start_word_i (op), .load_words_i (words), .ks_ready_i (ready),
    .busy_o (busy), .ks_valid_o (valid), .ks_data_o (data)
  );

  function automatic logic [14:0] dconst(input int i);
    case (i)
      0: return 15'h44D7;  1: return 15'h26BC;  2: return 15'h626B;  3: return 15'h135E;
      4: return 15'h5789;  5: return 15'h35E2;  6: return 15'h7135;  7: return 15'h09AF;
      8: return 15'h4D78;  9: return 15'h2F13; 10: return 15'h6BC4; 11: return 15'h1AF1;
      12: return 15'h5E26; 13: return 15'h3C4D; 14: return 15'h789A; default: return 15'h47AC;
    endcase
  endfunction

  function automatic logic [30:0] kcell(input int i, input logic [7:0] k, input logic [7:0] iv);
    return {k, dconst(i), iv};
  endfunction

  // pack cells per R4; msb_fill sets the discarded bits 63 and 31
  task automatic make_load(input logic [7:0] k, input logic [7:0] iv, input logic msb_fill);
    for (int j = 0; j < 7; j++)
      words[64*j +: 64] = {msb_fill, kcell(2*j, k, iv), msb_fill, kcell(2*j+1, k, iv)};
    op = {msb_fill, kcell(14, k, iv), msb_fill, kcell(15, k, iv)};
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; ready = 1'b0; resume = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start(input logic res);
    resume = res; start = 1'b1;
    @(negedge clk);
    start = 1'b0; resume = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
  endtask

  task automatic get_word(output logic [31:0] w);
    int g = 0;
    while (!valid && g < 100) begin g++; @(negedge clk); end
    w = data;
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, z1_ref;
    logic [31:0] seq_a [8];
    logic [31:0] seq_b [8];
    int n;

    do_reset();
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 valid after reset", 32'(valid), 32'd0);

    // known answer, all-zero key and IV
    make_load(8'h00, 8'h00, 1'b0);
    pulse_start(1'b0);
    chk("R2 busy after start", 32'(busy), 32'd1);
    wait_idle(n);
    chk("R2 busy length", n, 33);
    chk("R2 valid after init", 32'(valid), 32'd1);
    get_word(w); chk("R6 zero-key z1", w, 32'h27BEDE74);
    get_word(w); chk("R6 zero-key z2", w, 32'h018082DA);

    // known answer, all-ones key and IV
    make_load(8'hFF, 8'hFF, 1'b0);
    pulse_start(1'b0);
    wait_idle(n);
    get_word(w); chk("R6 ones-key z1", w, 32'h0657CFA0);
    get_word(w); chk("R6 ones-key z2", w, 32'h7096398B);

    // discarded half-word msbs set
    make_load(8'h00, 8'h00, 1'b1);
    pulse_start(1'b0);
    wait_idle(n);
    get_word(w); chk("R4 msb discard z1", w, 32'h27BEDE74);
    get_word(w); chk("R4 msb discard z2", w, 32'h018082DA);

    // restart while a word is offered
    chk("R8 valid before restart", 32'(valid), 32'd1);
    make_load(8'h00, 8'h00, 1'b0);
    pulse_start(1'b0);
    chk("R8 valid drops", 32'(valid), 32'd0);
    chk("R8 busy on restart", 32'(busy), 32'd1);
    wait_idle(n);
    get_word(w); chk("R8 restart z1", w, 32'h27BEDE74);

    // spurious start at every busy cycle offset
    for (int off = 0; off < 33; off++) begin
      make_load(8'h00, 8'h00, 1'b0);
      pulse_start(1'b0);
      repeat (off) @(negedge clk);
      make_load(8'hFF, 8'hFF, 1'b0);
      pulse_start(1'b1);
      wait_idle(n);
      chk($sformatf("R3 busy length off %0d", off), n, 32 - off);
      get_word(w);
      chk($sformatf("R3 z1 off %0d", off), w, 32'h27BEDE74);
    end

    // handshake: reference under full throughput, then with stalls
    make_load(8'h00, 8'h00, 1'b0);
    pulse_start(1'b0);
    wait_idle(n);
    for (int k = 0; k < 8; k++) get_word(seq_a[k]);
    chk("R7 stream word 0", seq_a[0], 32'h27BEDE74);
    chk("R7 stream word 1", seq_a[1], 32'h018082DA);
    pulse_start(1'b0);
    wait_idle(n);
    for (int k = 0; k < 8; k++) begin
      for (int s = 0; s < (k % 3) + 1; s++) begin
        w = data;
        @(negedge clk);
        chk($sformatf("R7 hold data word %0d", k), data, w);
        chk($sformatf("R7 hold valid word %0d", k), 32'(valid), 32'd1);
      end
      get_word(w);
      chk($sformatf("R7 stalled word %0d", k), w, seq_a[k]);
    end

    // resume after reset with garbage load words vs explicit zero load
    do_reset();
    for (int j = 0; j < 7; j++) words[64*j +: 64] = 64'h5A5A_A5A5_3C3C_C3C3;
    op = 64'h1234_5678_0ABC_DEF1;
    pulse_start(1'b1);
    wait_idle(n);
    for (int k = 0; k < 4; k++) get_word(seq_b[k]);
    do_reset();
    words = '0;
    pulse_start(1'b0);
    wait_idle(n);
    for (int k = 0; k < 4; k++) begin
      get_word(w);
      chk($sformatf("R5 resume word %0d", k), seq_b[k], w);
    end
    z1_ref = seq_b[0];
    chk("R5 resume differs from known answer", 32'(z1_ref != 32'h27BEDE74), 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule